// File: doc/BRIEF.md
# MDIO Management Bus Master

This block drives the two-wire PHY management bus (MDC clock, bidirectional MDIO data) on behalf of a host. The host programs a command word holding a start/busy flag, a direction flag, a 5-bit PHY address, a register number and a 3-bit clock-select code. For writes it also programs a 16-bit data word. While a frame is in flight the block derives MDC from the system clock, shifts out a clause-22 management frame MSB first and controls the MDIO output enable.

When the frame finishes, the busy flag drops by itself. After a read, the data word holds the 16 bits the PHY returned. The host polls the busy flag through the same register port it uses to launch transfers. Any write that arrives while a frame is running has no effect.

Top module: `mdio_master`

## Requirements
- R1: After reset the busy flag (command bit 0) reads 0, the data word reads 0, MDC is low and the MDIO output enable is low.
- R2: A command write with bit 0 set while idle starts a frame, and busy reads 1 until the frame ends. A command write with bit 0 clear stores the fields (readable back) but starts nothing, and MDC stays low.
- R3: Each frame is, MSB first: 32 ones, start bits 01, opcode (01 when command bit 1 is 1 for write, 10 when it is 0 for read), PHY address from command bits 16:12, and register number from command bits 8:4. Command bits 10:9 are stored but not sent.
- R4: A write frame ends with turnaround 10 and then the 16-bit data word. The output enable stays high for all 64 bits.
- R5: A read frame drops the output enable from the first turnaround bit to the end. It samples MDIO on each MDC rising edge of the 16 data bits and stores them, MSB first, in the data word when the frame ends.
- R6: MDC half period in system clocks follows command bits 22:20: codes 0..7 give 8, 13, 21, 31, 51, 62, 4 and 4. Busy clears exactly 128 half periods after the clock edge that accepted the start.
- R7: A command write while busy is ignored: fields, frame and timing are unchanged.
- R8: A data-word write while busy is ignored.
- R9: Whenever busy is 0, MDC is low and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 command word, 1 data word |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench models a PHY that records every bit on MDC rising edges and answers reads one bit per falling edge. It goes after several corner cases. Register numbers with bits 10:9 set would leak into the address field if the field were cut wrong. Slow and fast clock codes would expose a wrong divide ratio or an off-by-one in the half-period counter as a frame length other than 128 half periods. A late release of the output enable at turnaround would drive against the PHY. Commands and data written mid-frame would corrupt the running frame or the write data if not blocked. A command with the start bit clear must not launch MDC activity.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_BUSY = 0;
  localparam int CMD_WR   = 1;
  localparam int REG_LSB  = 4;
  localparam int REG_MSB  = 10;
  localparam int PHY_LSB  = 12;
  localparam int PHY_MSB  = 16;
  localparam int SEL_LSB  = 20;
  localparam int SEL_MSB  = 22;
  localparam int HALF_W   = 6;

  // half of the MDC divide ratio per clock-select code
  function automatic logic [HALF_W-1:0] half_period(input logic [2:0] code);
    case (code)
      3'd0:    half_period = HALF_W'(8);
      3'd1:    half_period = HALF_W'(13);
      3'd2:    half_period = HALF_W'(21);
      3'd3:    half_period = HALF_W'(31);
      3'd4:    half_period = HALF_W'(51);
      3'd5:    half_period = HALF_W'(62);
      default: half_period = HALF_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
  import mdio_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [2:0] sel_i,
  output logic       mdc_o,
  output logic       rise_o,
  output logic       fall_o
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half;
  logic              term;

  assign half   = half_period(sel_i);
  assign term   = run_i && (cnt_q == half - HALF_W'(1));
  assign rise_o = term && !mdc_o;
  assign fall_o = term && mdc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_o <= ~mdc_o;
    end else begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < half); // R6
  AST_MDC_TOGGLES_ON_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !term |=> $stable(mdc_o)); // R6
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame #(
  parameter int PRE_LEN = 32,
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [PHY_W-1:0]  phy_i,
  input  logic [REG_W-1:0]  regad_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int FRAME_LEN = PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;
  localparam int TA_POS    = PRE_LEN + 4 + PHY_W + REG_W;
  localparam int DATA_POS  = TA_POS + 2;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] TA_C   = CNT_W'(TA_POS);
  localparam logic [CNT_W-1:0] DATA_C = CNT_W'(DATA_POS);

  logic                 active_q;
  logic                 wr_q;
  logic [FRAME_LEN-1:0] tx_sr;
  logic [CNT_W-1:0]     bit_cnt;
  logic [DATA_W-1:0]    rx_sr;

  assign done_o    = active_q && fall_i && (bit_cnt == LAST_C);
  assign mdio_o    = active_q && tx_sr[FRAME_LEN-1];
  assign mdio_oe_o = active_q && (wr_q || (bit_cnt < TA_C));
  assign rdata_o   = rx_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      tx_sr    <= '0;
      bit_cnt  <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      wr_q     <= wr_i;
      bit_cnt  <= '0;
      tx_sr    <= {{PRE_LEN{1'b1}}, 2'b01, (wr_i ? 2'b01 : 2'b10), phy_i, regad_i,
                   (wr_i ? 2'b10 : 2'b11), (wr_i ? wdata_i : {DATA_W{1'b1}})};
    end else if (active_q && fall_i) begin
      if (bit_cnt == LAST_C) begin
        active_q <= 1'b0;
      end else begin
        bit_cnt <= bit_cnt + CNT_W'(1);
        tx_sr   <= {tx_sr[FRAME_LEN-2:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sr <= '0;
    end else if (active_q && rise_i && !wr_q && (bit_cnt >= DATA_C)) begin
      rx_sr <= {rx_sr[DATA_W-2:0], mdio_i};
    end
  end

  AST_START_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q); // R7
  AST_TX_SHIFT_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !fall_i |=> $stable(tx_sr)); // R3
  AST_RX_HOLD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && wr_q |=> $stable(rx_sr)); // R4
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam logic [31:0] CMD_MASK =
    (32'h7 << SEL_LSB) | (32'h1F << PHY_LSB) | (32'h7F << REG_LSB) | (32'h1 << CMD_WR);

  logic              busy_q;
  logic [31:0]       cmd_q;
  logic [DATA_W-1:0] data_q;
  logic              cmd_acc, data_acc, start;
  logic              rise, fall, done;
  logic [DATA_W-1:0] rx_data;

  assign cmd_acc  = reg_we_i && !reg_addr_i && !busy_q;
  assign data_acc = reg_we_i && reg_addr_i && !busy_q;
  assign start    = cmd_acc && reg_wdata_i[CMD_BUSY];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cmd_q  <= '0;
    end else begin
      if (cmd_acc) cmd_q <= reg_wdata_i & CMD_MASK;
      if (start) busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (data_acc) begin
      data_q <= reg_wdata_i[DATA_W-1:0];
    end else if (done && !cmd_q[CMD_WR]) begin
      data_q <= rx_data;
    end
  end

  always_comb begin
    if (reg_addr_i) reg_rdata_o = {{(32-DATA_W){1'b0}}, data_q};
    else            reg_rdata_o = cmd_q | {31'b0, busy_q};
  end

  mdio_clk_div u_clk_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .sel_i  (cmd_q[SEL_MSB:SEL_LSB]),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame #(
    .PRE_LEN (32),
    .PHY_W   (PHY_W),
    .REG_W   (REG_W),
    .DATA_W  (DATA_W)
  ) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .wr_i      (reg_wdata_i[CMD_WR]),
    .phy_i     (reg_wdata_i[PHY_LSB +: PHY_W]),
    .regad_i   (reg_wdata_i[REG_LSB +: REG_W]),
    .wdata_i   (data_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_o    (done),
    .rdata_o   (rx_data)
  );

  AST_MDC_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !mdc_o); // R9
  AST_OE_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !mdio_oe_o); // R9
  AST_CMD_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(cmd_q)); // R7
  AST_DATA_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(data_q)); // R8
  AST_DONE_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> busy_q && fall); // R6
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_addr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mdio_master dut (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .mdc_o, .mdio_o, .mdio_oe_o, .mdio_i
  );

  // PHY model
  int          bit_k = 0;
  logic [63:0] cap, oe_cap;
  logic [15:0] resp_q = '0;

  always @(posedge mdc_o) begin
    if (bit_k < 64) begin
      cap[63-bit_k]    = mdio_o;
      oe_cap[63-bit_k] = mdio_oe_o;
    end
    bit_k = bit_k + 1;
  end

  always @(negedge mdc_o) begin
    if (bit_k == 47) mdio_i = 1'b0;
    else if (bit_k >= 48 && bit_k <= 63) mdio_i = resp_q[63-bit_k];
    else mdio_i = 1'b1;
  end

  // {wr, phy[4:0], reg[6:0], sel[2:0], wdata[15:0], resp[15:0]}
  localparam logic [47:0] VEC [6] = '{
    {1'b1, 5'h01, 7'h00, 3'd6, 16'hA5C3, 16'h0000},
    {1'b0, 5'h1F, 7'h01, 3'd6, 16'h0000, 16'h1234},
    {1'b1, 5'h10, 7'h7F, 3'd7, 16'h0001, 16'h0000},
    {1'b0, 5'h00, 7'h62, 3'd0, 16'h0000, 16'h8001},
    {1'b1, 5'h0A, 7'h15, 3'd1, 16'hFFFF, 16'h0000},
    {1'b0, 5'h05, 7'h0A, 3'd5, 16'h0000, 16'h5AA5}
  };

  function automatic int half_exp(input logic [2:0] c);
    case (c)
      3'd0: return 8;   3'd1: return 13;  3'd2: return 21;  3'd3: return 31;
      3'd4: return 51;  3'd5: return 62;  default: return 4;
    endcase
  endfunction

  function automatic logic [31:0] cmd_word(input logic wr, input logic [4:0] phy,
                                           input logic [6:0] rg, input logic [2:0] sel,
                                           input logic go);
    return (32'(sel) << 20) | (32'(phy) << 12) | (32'(rg) << 4) | (32'(wr) << 1) | 32'(go);
  endfunction

  function automatic logic [63:0] frame_exp(input logic wr, input logic [4:0] phy,
                                            input logic [6:0] rg, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg[4:0],
            (wr ? 2'b10 : 2'b11), (wr ? wd : 16'hFFFF)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic addr, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = addr; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_addr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic reg_read(input logic addr, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = addr;
    #1 d = reg_rdata_o;
    reg_addr_i = 1'b0;
  endtask

  // counts edges after the accepting edge until busy reads 0
  task automatic wait_idle(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (reg_rdata_o[0] && n < 20000);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    reg_read(1'b0, rd);
    check(rd[0] == 1'b0, "R1 busy", 64'(rd[0]), 64'h0);
    reg_read(1'b1, rd);
    check(rd == 32'h0, "R1 data", 64'(rd), 64'h0);
    check(!mdc_o && !mdio_oe_o, "R1 mdc/oe", {mdc_o, mdio_oe_o}, 64'h0);

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      logic wr; logic [4:0] phy; logic [6:0] rg; logic [2:0] sel;
      logic [15:0] wd, rp; logic [63:0] fe;
      {wr, phy, rg, sel, wd, rp} = VEC[i];
      resp_q = rp;
      bit_k = 0;
      if (wr) reg_write(1'b1, {16'h0, wd});
      reg_write(1'b0, cmd_word(wr, phy, rg, sel, 1'b1));
      check(reg_rdata_o[0] == 1'b1, "R2 busy set", 64'(reg_rdata_o[0]), 64'h1);
      wait_idle(n);
      check(n == 128 * half_exp(sel), "R6 frame length", 64'(n), 64'(128 * half_exp(sel)));
      fe = frame_exp(wr, phy, rg, wd);
      check(bit_k == 64, "R3 bit count", 64'(bit_k), 64'd64);
      if (wr) begin
        check(cap == fe, "R4 write frame", cap, fe);
        check(oe_cap == '1, "R4 oe held", oe_cap, '1);
      end else begin
        check(cap[63:18] == fe[63:18], "R3 read header", 64'(cap[63:18]), 64'(fe[63:18]));
        check(oe_cap == {46'h3FFF_FFFF_FFFF, 18'h0}, "R5 oe release", oe_cap,
              {46'h3FFF_FFFF_FFFF, 18'h0});
        reg_read(1'b1, rd);
        check(rd[15:0] == rp, "R5 read data", 64'(rd[15:0]), 64'(rp));
      end
      check(!mdc_o && !mdio_oe_o, "R9 idle outputs", {mdc_o, mdio_oe_o}, 64'h0);
    end

    // R2: command without start bit stores fields, no activity
    reg_write(1'b0, cmd_word(1'b0, 5'h07, 7'h63, 3'd2, 1'b0));
    reg_read(1'b0, rd);
    check(rd == cmd_word(1'b0, 5'h07, 7'h63, 3'd2, 1'b0), "R2 stored fields",
          64'(rd), 64'(cmd_word(1'b0, 5'h07, 7'h63, 3'd2, 1'b0)));
    n = 0;
    repeat (40) begin
      @(negedge clk_i);
      if (mdc_o || reg_rdata_o[0]) n++;
    end
    check(n == 0, "R2 no start", 64'(n), 64'h0);

    // R7 R8: writes during a running frame are ignored
    bit_k = 0;
    reg_write(1'b1, 32'h0000_1111);
    reg_write(1'b0, cmd_word(1'b1, 5'h03, 7'h04, 3'd6, 1'b1));
    repeat (50) @(negedge clk_i);
    reg_write(1'b0, cmd_word(1'b0, 5'h1C, 7'h11, 3'd0, 1'b1));
    reg_write(1'b1, 32'h0000_2222);
    reg_read(1'b0, rd);
    check(rd == cmd_word(1'b1, 5'h03, 7'h04, 3'd6, 1'b1), "R7 cmd readback",
          64'(rd), 64'(cmd_word(1'b1, 5'h03, 7'h04, 3'd6, 1'b1)));
    wait_idle(n);
    check(cap == frame_exp(1'b1, 5'h03, 7'h04, 16'h1111), "R7 frame unchanged",
          cap, frame_exp(1'b1, 5'h03, 7'h04, 16'h1111));
    reg_read(1'b1, rd);
    check(rd == 32'h1111, "R8 data unchanged", 64'(rd), 64'h1111);
    check(bit_k == 64, "R7 single frame", 64'(bit_k), 64'd64);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule